// File: doc/BRIEF.md
# Sub-Vector Fold Sequencer

This block walks a vector of up to 64 elements, where each element is a small group of 2, 3 or 4 lanes held in consecutive register-file entries. For every element it folds the lanes into a single 64-bit scalar with one binary operation (add, and, or, xor) and stores that scalar in a destination entry. The first lane comes from source group A; every later lane comes from source group B. The destination entry serves as the accumulator: after each fold step the partial result is written there and read back for the next step. A fold can therefore be stopped between any two steps and picked up later.

The sequencer drives two combinational read ports and one write port of an external register array. Per-element predication skips elements, and an optional 3-bit sign flag is produced for each folded element. A scalar destination ends the walk after the first active element. An interrupt request stops the walk at the next step boundary. The block reports the element and step to restart from, and a later start with the resume option set continues from exactly that point.

Top module: `subvec_fold`

## Requirements
- R1: The lane count per element is 2, 3 or 4 (`svl`). Each active element takes exactly `svl`-1 fold steps, one write per clock, and nothing is written while the sequencer is idle.
- R2: Lane k of element i of a source group sits at base + i*`svl` + k (modulo the address space). Step 0 combines lane 0 of group A with lane 1 of group B. Step s>0 combines the running result with lane s+1 of group B, in ascending lane order.
- R3: Group layout applies only to the sources. The result of element i goes to entry `base_t`+i, or to `base_t` itself when `dst_scalar` is set.
- R4: Every step writes its partial result to the destination entry. Steps after the first read the running value back from that entry through port A.
- R5: With `flag_en` set, each active element yields one flag write carrying its index and the sign of its final value as a one-hot code: bit 2 negative, bit 1 positive, bit 0 zero (signed 64-bit). With `flag_en` clear, no flag is written.
- R6: With `dst_scalar` set, the walk ends after the first element whose predicate bit is set, or after element 0 when predication is off.
- R7: With `pred_en` set, an element whose bit in `pred_mask` is clear is skipped in zero cycles, and its destination entry and flag are left unchanged.
- R8: `done` is high for one cycle, in the cycle after the final write. A `start` while busy is ignored.
- R9: When `irq` is high in a busy cycle, that cycle's step still commits and `busy` drops. If work remains, `halted` pulses for one cycle and `save_elem`/`save_step` name the next step. A start with `resume` set and those values completes with the same final state as an uninterrupted run. If the committed step was the last one, `done` pulses instead.
- R10: A start with `vl` of 0, or with no active element, raises `done` in the next cycle with no writes.
- R11: `op` encodes 0 add (modulo 2^64), 1 bitwise and, 2 bitwise or, 3 bitwise xor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk, sampled while idle |
| resume | input | 1 | Start from `resume_elem`/`resume_step` instead of element 0 |
| vl | input | 7 | Element count, 0 to 64 |
| svl | input | 3 | Lanes per element, 2 to 4 |
| op | input | 2 | Fold operation code |
| base_a | input | 8 | First entry of source group A |
| base_b | input | 8 | First entry of source group B |
| base_t | input | 8 | First destination entry |
| dst_scalar | input | 1 | Destination is a single entry; stop after the first active element |
| pred_en | input | 1 | Apply `pred_mask` |
| pred_mask | input | 64 | One enable bit per element |
| flag_en | input | 1 | Emit a sign flag per element |
| resume_elem | input | 6 | Element to restart from |
| resume_step | input | 2 | Step to restart from within that element |
| irq | input | 1 | Stop at the next step boundary |
| ra_addr | output | 8 | Read address, port A |
| ra_data | input | 64 | Read data, port A (same cycle) |
| rb_addr | output | 8 | Read address, port B |
| rb_data | input | 64 | Read data, port B (same cycle) |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 8 | Destination write address |
| wr_data | output | 64 | Partial or final folded value |
| flag_we | output | 1 | Flag write strobe |
| flag_idx | output | 6 | Element index of the flag |
| flag | output | 3 | One-hot sign code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk complete pulse |
| halted | output | 1 | Walk interrupted pulse |
| save_elem | output | 6 | Element to resume from |
| save_step | output | 2 | Step to resume from |

## Verification
The properties assume that `svl` is 2, 3 or 4, that `vl` does not exceed 64, and that any `resume_step` lies below `svl`-1 for the resumed element. They also assume that the register array returns read data in the same cycle as the address and applies writes at the clock edge. The bench models the array in exactly that way. It draws every configuration from these legal sets, and it only resumes with the `save_elem`/`save_step` pair that the block itself reported. The sign properties also rely on the flag being produced from the same value that goes out on `wr_data` in that cycle, which holds for a single-cycle fold step.

// File: rtl/subvec_fold.sv
module subvec_fold #(
  parameter int XLEN  = 64,
  parameter int AW    = 8,
  parameter int MAXVL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             resume,
  input  logic [$clog2(MAXVL+1)-1:0] vl,
  input  logic [2:0]       svl,
  input  logic [1:0]       op,
  input  logic [AW-1:0]    base_a,
  input  logic [AW-1:0]    base_b,
  input  logic [AW-1:0]    base_t,
  input  logic             dst_scalar,
  input  logic             pred_en,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             flag_en,
  input  logic [$clog2(MAXVL)-1:0] resume_elem,
  input  logic [1:0]       resume_step,
  input  logic             irq,
  output logic [AW-1:0]    ra_addr,
  input  logic [XLEN-1:0]  ra_data,
  output logic [AW-1:0]    rb_addr,
  input  logic [XLEN-1:0]  rb_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [XLEN-1:0]  wr_data,
  output logic             flag_we,
  output logic [$clog2(MAXVL)-1:0] flag_idx,
  output logic [2:0]       flag,
  output logic             busy,
  output logic             done,
  output logic             halted,
  output logic [$clog2(MAXVL)-1:0] save_elem,
  output logic [1:0]       save_step
);
  localparam int EW = $clog2(MAXVL + 1);
  localparam int IW = $clog2(MAXVL);
  localparam int PW = IW + 3;

  logic             busy_q, done_q, halt_q;
  logic [IW-1:0]    elem_q, save_elem_q;
  logic [1:0]       step_q, save_step_q;
  logic [EW-1:0]    vl_q;
  logic [2:0]       svl_q;
  logic [1:0]       op_q;
  logic [AW-1:0]    ba_q, bb_q, bt_q;
  logic             scal_q, pen_q, fen_q;
  logic [MAXVL-1:0] mask_q;

  int               from_i, lim_i;
  logic [MAXVL-1:0] act;
  logic             hit;
  logic [IW-1:0]    nxt;

  always_comb begin
    if (busy_q) begin
      from_i = int'(elem_q) + 1;
      lim_i  = int'(vl_q);
      act    = pen_q ? mask_q : '1;
    end else begin
      from_i = resume ? int'(resume_elem) : 0;
      lim_i  = int'(vl);
      act    = pred_en ? pred_mask : '1;
    end
    hit = 1'b0;
    nxt = '0;
    for (int k = MAXVL - 1; k >= 0; k--)
      if (k >= from_i && k < lim_i && act[k]) begin
        hit = 1'b1;
        nxt = IW'(k);
      end
  end

  logic [XLEN-1:0] res;
  always_comb
    case (op_q)
      2'd0:    res = ra_data + rb_data;
      2'd1:    res = ra_data & rb_data;
      2'd2:    res = ra_data | rb_data;
      default: res = ra_data ^ rb_data;
    endcase

  logic [PW-1:0] grp_full;
  logic [AW-1:0] grp, dst;
  logic          last, neg, zero;

  assign grp_full = PW'(elem_q) * PW'(svl_q);
  assign grp      = AW'(grp_full);
  assign dst      = bt_q + (scal_q ? AW'(0) : AW'(elem_q));
  assign last     = ({1'b0, step_q} == svl_q - 3'd2);
  assign neg      = res[XLEN-1];
  assign zero     = (res == '0);

  assign ra_addr   = (step_q == 2'd0) ? ba_q + grp : dst;
  assign rb_addr   = bb_q + grp + AW'(step_q) + AW'(1);
  assign wr_en     = busy_q;
  assign wr_addr   = dst;
  assign wr_data   = res;
  assign flag_we   = busy_q & last & fen_q;
  assign flag_idx  = elem_q;
  assign flag      = {neg, ~neg & ~zero, zero};
  assign busy      = busy_q;
  assign done      = done_q;
  assign halted    = halt_q;
  assign save_elem = save_elem_q;
  assign save_step = save_step_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; halt_q <= 1'b0;
      elem_q <= '0; step_q <= '0; save_elem_q <= '0; save_step_q <= '0;
      vl_q <= '0; svl_q <= 3'd2; op_q <= '0;
      ba_q <= '0; bb_q <= '0; bt_q <= '0;
      scal_q <= 1'b0; pen_q <= 1'b0; fen_q <= 1'b0; mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      halt_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          vl_q   <= vl;      svl_q <= svl;     op_q  <= op;
          ba_q   <= base_a;  bb_q  <= base_b;  bt_q  <= base_t;
          scal_q <= dst_scalar; pen_q <= pred_en; fen_q <= flag_en;
          mask_q <= pred_mask;
          if (hit) begin
            busy_q <= 1'b1;
            elem_q <= nxt;
            step_q <= (resume && nxt == resume_elem) ? resume_step : 2'd0;
          end else
            done_q <= 1'b1;
        end
      end else if (last) begin
        if (scal_q || !hit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          elem_q <= nxt;
          step_q <= 2'd0;
          if (irq) begin
            busy_q      <= 1'b0;
            halt_q      <= 1'b1;
            save_elem_q <= nxt;
            save_step_q <= 2'd0;
          end
        end
      end else begin
        step_q <= step_q + 2'd1;
        if (irq) begin
          busy_q      <= 1'b0;
          halt_q      <= 1'b1;
          save_elem_q <= elem_q;
          save_step_q <= step_q + 2'd1;
        end
      end
    end
endmodule

// File: rtl/subvec_fold_chk.sv
module subvec_fold_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            halted,
  input logic            irq,
  input logic            wr_en,
  input logic            flag_we,
  input logic [2:0]      flag,
  input logic [XLEN-1:0] wr_data
);
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_BUSY_ENDS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || halted)); // R8
  AST_DONE_HALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(done && halted)); // R9
  AST_IRQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n) (busy && irq) |=> !busy); // R9
  AST_FLAG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> wr_en); // R5
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) flag_we |-> $onehot(flag)); // R5
  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (flag_we && flag[0]) |-> (wr_data == '0)); // R5
  AST_FLAG_NEG: assert property (@(posedge clk) disable iff (!rst_n) (flag_we && flag[2]) |-> wr_data[XLEN-1]); // R5
endmodule

bind subvec_fold subvec_fold_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .halted(halted), .irq(irq),
  .wr_en(wr_en), .flag_we(flag_we), .flag(flag), .wr_data(wr_data)
);

// File: tb/sim_subvec_fold.sv
module sim_subvec_fold;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, resume = 0, dst_scalar = 0, pred_en = 0, flag_en = 0, irq = 0;
  logic [6:0]  vl = 0;
  logic [2:0]  svl = 3'd2;
  logic [1:0]  op = 0, resume_step = 0;
  logic [7:0]  base_a = 8'd0, base_b = 8'd64, base_t = 8'd160;
  logic [63:0] pred_mask = 0;
  logic [5:0]  resume_elem = 0;
  logic [7:0]  ra_addr, rb_addr, wr_addr;
  logic [63:0] ra_data, rb_data, wr_data;
  logic        wr_en, flag_we, busy, done, halted;
  logic [5:0]  flag_idx, save_elem;
  logic [2:0]  flag;
  logic [1:0]  save_step;

  logic [63:0] rf [256];
  logic [63:0] exp_rf [256];
  logic [2:0]  fl [64];
  logic [2:0]  exp_fl [64];
  int          wcnt, exp_writes, total = 0, fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  subvec_fold u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .vl(vl), .svl(svl), .op(op),
    .base_a(base_a), .base_b(base_b), .base_t(base_t), .dst_scalar(dst_scalar),
    .pred_en(pred_en), .pred_mask(pred_mask), .flag_en(flag_en),
    .resume_elem(resume_elem), .resume_step(resume_step), .irq(irq),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flag_we(flag_we),
    .flag_idx(flag_idx), .flag(flag), .busy(busy), .done(done), .halted(halted),
    .save_elem(save_elem), .save_step(save_step)
  );

  assign ra_data = rf[ra_addr];
  assign rb_data = rf[rb_addr];

  always @(posedge clk) begin
    if (wr_en) begin
      rf[wr_addr] <= wr_data;
      wcnt <= wcnt + 1;
    end
    if (flag_we) fl[flag_idx] <= flag;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [63:0] apply(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
    case (o)
      2'd0: return a + b;
      2'd1: return a & b;
      2'd2: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [2:0] sign3(input logic [63:0] v);
    if (v == 0) return 3'b001;
    if (v[63]) return 3'b100;
    return 3'b010;
  endfunction

  task automatic fill();
    for (int i = 0; i < 256; i++) begin
      rf[i] = {lcg(), lcg()};
      if (i % 11 == 5) rf[i] = 64'd0;
    end
    for (int i = 0; i < 64; i++) fl[i] = 3'b000;
  endtask

  task automatic model();
    int n;
    logic [63:0] acc;
    n = 0;
    for (int i = 0; i < 256; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 64; i++) exp_fl[i] = 3'b000;
    for (int i = 0; i < int'(vl); i++) begin
      if (!pred_en || pred_mask[i]) begin
        acc = apply(op, rf[8'(int'(base_a) + i * int'(svl))], rf[8'(int'(base_b) + i * int'(svl) + 1)]);
        for (int k = 2; k < int'(svl); k++)
          acc = apply(op, acc, rf[8'(int'(base_b) + i * int'(svl) + k)]);
        exp_rf[8'(int'(base_t) + (dst_scalar ? 0 : i))] = acc;
        if (flag_en) exp_fl[i] = sign3(acc);
        n++;
        if (dst_scalar) break;
      end
    end
    exp_writes = n * (int'(svl) - 1);
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    for (int i = 255; i >= 0; i--) if (rf[i] !== exp_rf[i]) bad = i;
    if (bad < 0) chk(1'b1, {tag, " R2 R3 R4 R6 R7 R11 destination"}, 0, 0);
    else chk(1'b0, {tag, " R2 R3 R4 R6 R7 R11 destination"}, rf[bad], exp_rf[bad]);
    bad = -1;
    for (int i = 63; i >= 0; i--) if (fl[i] !== exp_fl[i]) bad = i;
    if (bad < 0) chk(1'b1, {tag, " R5 R7 flags"}, 0, 0);
    else chk(1'b0, {tag, " R5 R7 flags"}, 64'(fl[bad]), 64'(exp_fl[bad]));
  endtask

  task automatic wait_end(output int k, input bit poke);
    k = 0;
    while (!done && !halted && k < 1000) begin
      if (poke && k == 1) begin start = 1; vl = 7'd0; end
      @(negedge clk);
      if (poke && k == 1) begin start = 0; vl = 7'd8; end
      k++;
    end
  endtask

  task automatic run(input bit poke);
    int k;
    model();
    wcnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_end(k, poke);
    chk(k == exp_writes && done, "R1 R8 R10 done cycle", 64'(k), 64'(exp_writes));
    chk(wcnt == exp_writes, "R1 R10 write count", 64'(wcnt), 64'(exp_writes));
    compare(poke ? "R8 start-while-busy" : "sweep");
  endtask

  task automatic irq_run(input int m);
    int k, f;
    vl = 7'd5; svl = 3'd4; op = 2'd0; pred_en = 0; dst_scalar = 0; flag_en = 1;
    fill();
    model();
    start = 1;
    @(negedge clk);
    start = 0;
    k = 0;
    while (!done && !halted && k < 1000) begin
      if (k == m) irq = 1;
      @(negedge clk);
      k++;
    end
    irq = 0;
    f = m + 1;
    if (m < 14) begin
      chk(halted && !busy && k == f, "R9 halt timing", 64'(k), 64'(f));
      chk(save_elem == 6'(f / 3) && save_step == 2'(f % 3), "R9 saved position",
          64'({save_elem, save_step}), 64'({6'(f / 3), 2'(f % 3)}));
      resume = 1; resume_elem = save_elem; resume_step = save_step; start = 1;
      @(negedge clk);
      start = 0; resume = 0;
      wait_end(k, 1'b0);
      chk(done, "R9 resumed walk completes", 64'(done), 64'd1);
    end else
      chk(done && !halted && k == 15, "R9 irq on final step gives done", 64'(k), 64'd15);
    compare("R9 R4 interrupted");
  endtask

  initial begin
    #(8 * 190000);
    total++; fails++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 64'd0;
    for (int i = 0; i < 64; i++) fl[i] = 3'b000;
    wcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !halted && !wr_en && !flag_we, "R1 R8 reset state",
        64'({busy, done, halted, wr_en, flag_we}), 64'd0);

    for (int vi = 0; vi < 5; vi++)
      for (int s = 2; s <= 4; s++)
        for (int o = 0; o < 4; o++)
          for (int p = 0; p < 2; p++)
            for (int sc = 0; sc < 2; sc++) begin
              case (vi)
                0: vl = 7'd0;
                1: vl = 7'd1;
                2: vl = 7'd2;
                3: vl = 7'd5;
                default: vl = 7'd8;
              endcase
              svl = 3'(s); op = 2'(o); pred_en = p[0]; dst_scalar = sc[0];
              pred_mask = 64'h5A; flag_en = (o != 2);
              fill();
              run(1'b0);
            end

    vl = 7'd64; svl = 3'd4; op = 2'd3; pred_en = 0; dst_scalar = 0; flag_en = 1;
    base_a = 8'd0; base_b = 8'd0; base_t = 8'd0;
    fill();
    for (int i = 0; i < 256; i++) rf[i] = 64'(i) * 64'h0101_0101_0101_0101;
    model();
    wcnt = 0; start = 1;
    @(negedge clk);
    start = 0;
    begin
      int k;
      wait_end(k, 1'b0);
      chk(k == 192 && wcnt == 192, "R1 R2 full-length wrap run", 64'(k), 64'd192);
    end
    base_a = 8'd0; base_b = 8'd64; base_t = 8'd160;

    vl = 7'd3; svl = 3'd2; op = 2'd3; pred_en = 0; dst_scalar = 0; flag_en = 1;
    fill();
    rf[8'd64 + 8'd3] = rf[8'd2];
    rf[8'd64 + 8'd5] = 64'h8000_0000_0000_0000 ^ rf[8'd4];
    run(1'b0);
    chk(fl[1] == 3'b001 && fl[2] == 3'b100, "R5 zero and negative flags",
        64'({fl[1], fl[2]}), 64'({3'b001, 3'b100}));

    vl = 7'd8; svl = 3'd4; op = 2'd0; pred_en = 0; dst_scalar = 0; flag_en = 1;
    fill();
    run(1'b1);

    for (int m = 0; m < 15; m++) irq_run(m);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule